// File: doc/BRIEF.md
# Indexed Color Palette Loader

This block holds a 256-entry color lookup table. Each entry has an 8-bit red, green and blue component. Software loads the table through two bus offsets. One offset holds the entry pointer. The other takes color bytes, which a small phase counter routes to red, green and blue of the pointed entry in that order. The pointer steps forward by one each time a blue byte lands.

A single data access may carry one to four bytes. They are consumed from the most significant carried byte downwards, so a four-byte write can finish one entry and begin the next in the same cycle.

On the scanout side, an 8-bit pixel code is turned into a packed 24-bit color after one clock. Any color data write raises a refresh request. The request stays set until the display side acknowledges it.

Top module: `palette_lut`

## Requirements
- R1: After reset every entry reads as zero on `rgb_o`, the component phase is red, the pointer is 0, and `refresh_req_o` is 1.
- R2: A write at offset 0x0 loads `wdata_i[7:0]` into the pointer and returns the phase to red. The next data byte goes to red of that entry.
- R3: Data bytes written at offset 0x4 are stored in turn to red (phase 0), green (phase 1) and blue (phase 2) of the pointed entry.
- R4: After a blue byte is stored, the pointer increments modulo 256 (255 wraps to 0) and the phase returns to red.
- R5: `wsize_i` gives the byte count minus one (0 means 1 byte, 3 means 4 bytes). An n-byte access carries its data in `wdata_i[8n-1:0]`. Bytes are consumed from byte n-1 down to byte 0, and each one advances the phase sequence as a separate write would.
- R6: `rgb_o` equals {red, green, blue} of entry `pix_i`, with red in bits 23:16, green in 15:8 and blue in 7:0. It reflects the `pix_i` value and table contents of the previous clock edge (one cycle of latency).
- R7: When a data write updates the entry that `pix_i` selects in the same cycle, `rgb_o` shows the old value in the next cycle and the new value one cycle later.
- R8: Any data write sets `refresh_req_o`. `refresh_clr_i` clears it, but a data write in the same cycle takes priority. Pointer writes leave it unchanged.
- R9: Writes to any offset other than 0x0 and 0x4 change neither the table, the pointer, the phase nor `refresh_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | 4 | Byte offset of the write |
| wdata_i | input | 32 | Write data, right-aligned |
| wsize_i | input | 2 | Byte count minus one |
| refresh_clr_i | input | 1 | Acknowledge that clears the refresh request |
| pix_i | input | 8 | Pixel code to look up |
| rgb_o | output | 24 | Looked-up color, registered |
| refresh_req_o | output | 1 | Palette changed, full refresh wanted |

## Verification
A write presented before edge t is in the table after edge t. The lookup result for a `pix_i` held across edge t is valid after edge t. A stored color therefore first appears on `rgb_o` after the edge that follows the write edge, and `refresh_req_o` changes right after the write edge. The bench drives on falling edges and samples on the falling edge after each relevant rising edge. It checks the same-cycle write and read pair once at the first sample and once more at the second. A bench model of the pointer, phase and table is updated per bus write, and it supplies the expected colors for directed and random sequences.

// File: rtl/palette_pkg.sv
package palette_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam logic [3:0] OFF_PTR  = 4'h0;
  localparam logic [3:0] OFF_DATA = 4'h4;
  localparam int unsigned NUM_COMP = 3;
endpackage

// File: rtl/palette_seq.sv
module palette_seq
  import palette_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned BUS_W = 32,
  localparam int unsigned LANES = BUS_W / 8,
  localparam int unsigned SZ_W  = $clog2(LANES)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             ptr_we_i,
  input  logic                             dat_we_i,
  input  logic [BUS_W-1:0]                 wdata_i,
  input  logic [SZ_W-1:0]                  wsize_i,
  output logic [LANES-1:0]                 lane_we_o,
  output logic [LANES-1:0][1:0]            lane_comp_o,
  output logic [LANES-1:0][IDX_W-1:0]      lane_idx_o,
  output logic [LANES-1:0][7:0]            lane_byte_o
);
  phase_e             phase_q;
  logic [IDX_W-1:0]   ptr_q;
  int unsigned        nbytes;

  assign nbytes = int'(wsize_i) + 1;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    int unsigned pos;
    int unsigned sh;
    assign pos = int'(phase_q) + k;
    assign sh  = (k < nbytes) ? 8 * (nbytes - 1 - k) : 0;
    assign lane_we_o[k]   = dat_we_i && (k < nbytes);
    assign lane_comp_o[k] = 2'(pos % NUM_COMP);
    assign lane_idx_o[k]  = ptr_q + IDX_W'(pos / NUM_COMP);
    assign lane_byte_o[k] = 8'(wdata_i >> sh);
  end

  int unsigned tot;
  assign tot = int'(phase_q) + nbytes;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_RED;
      ptr_q   <= '0;
    end else if (ptr_we_i) begin
      phase_q <= PH_RED;
      ptr_q   <= wdata_i[IDX_W-1:0];
    end else if (dat_we_i) begin
      phase_q <= phase_e'(2'(tot % NUM_COMP));
      ptr_q   <= ptr_q + IDX_W'(tot / NUM_COMP);
    end
  end

  assert_phase_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q != 2'd3);
  assert_ptr_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_we_i |=> (ptr_q == $past(wdata_i[IDX_W-1:0]) && phase_q == PH_RED));
  assert_ptr_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_we_i && !dat_we_i) |=> ($stable(ptr_q) && $stable(phase_q)));
  assert_one_byte_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_we_i && !ptr_we_i && wsize_i == '0 && phase_q == PH_BLU)
      |=> (phase_q == PH_RED && ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: rtl/palette_bank.sv
module palette_bank #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned DEPTH = 2 ** IDX_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [LANES-1:0]            we_i,
  input  logic [LANES-1:0][IDX_W-1:0] idx_i,
  input  logic [LANES-1:0][COMP_W-1:0] dat_i,
  input  logic [IDX_W-1:0]            rd_idx_i,
  output logic [COMP_W-1:0]           rd_o
);
  logic [COMP_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
      rd_o <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (we_i[l]) mem_q[idx_i[l]] <= dat_i[l];
      rd_o <= mem_q[rd_idx_i];
    end
  end

  assert_read_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i == '0 && $past(we_i) == '0 && rd_idx_i == $past(rd_idx_i)) |=> $stable(rd_o));
endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import palette_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned LANES = BUS_W / 8,
  localparam int unsigned SZ_W  = $clog2(LANES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [BUS_W-1:0]          wdata_i,
  input  logic [SZ_W-1:0]           wsize_i,
  input  logic                      refresh_clr_i,
  input  logic [IDX_W-1:0]          pix_i,
  output logic [NUM_COMP*COMP_W-1:0] rgb_o,
  output logic                      refresh_req_o
);
  logic ptr_we, dat_we;
  assign ptr_we = wr_en_i && (addr_i == ADDR_W'(OFF_PTR));
  assign dat_we = wr_en_i && (addr_i == ADDR_W'(OFF_DATA));

  logic [LANES-1:0]             lane_we;
  logic [LANES-1:0][1:0]        lane_comp;
  logic [LANES-1:0][IDX_W-1:0]  lane_idx;
  logic [LANES-1:0][7:0]        lane_byte;

  palette_seq #(.IDX_W(IDX_W), .BUS_W(BUS_W)) u_seq (
    .clk_i, .rst_ni,
    .ptr_we_i   (ptr_we),
    .dat_we_i   (dat_we),
    .wdata_i,
    .wsize_i,
    .lane_we_o  (lane_we),
    .lane_comp_o(lane_comp),
    .lane_idx_o (lane_idx),
    .lane_byte_o(lane_byte)
  );

  // comp 0 = red sits in the top field of rgb_o
  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    logic [LANES-1:0]              bank_we;
    logic [LANES-1:0][COMP_W-1:0]  bank_dat;
    for (genvar l = 0; l < LANES; l++) begin : g_l
      assign bank_we[l]  = lane_we[l] && (lane_comp[l] == 2'(c));
      assign bank_dat[l] = COMP_W'(lane_byte[l]);
    end
    palette_bank #(.IDX_W(IDX_W), .COMP_W(COMP_W), .LANES(LANES)) u_bank (
      .clk_i, .rst_ni,
      .we_i     (bank_we),
      .idx_i    (lane_idx),
      .dat_i    (bank_dat),
      .rd_idx_i (pix_i),
      .rd_o     (rgb_o[(NUM_COMP-1-c)*COMP_W +: COMP_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            refresh_req_o <= 1'b1;
    else if (dat_we)        refresh_req_o <= 1'b1;
    else if (refresh_clr_i) refresh_req_o <= 1'b0;
  end

  assert_refresh_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_we |=> refresh_req_o);
  assert_refresh_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_clr_i && !wr_en_i) |=> !refresh_req_o);
  assert_refresh_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dat_we && !refresh_clr_i) |=> $stable(refresh_req_o));
endmodule

// File: tb/tb_palette_lut.sv
module tb_palette_lut;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  wsize = '0;
  logic        rclr = 1'b0;
  logic [7:0]  pix = '0;
  logic [23:0] rgb;
  logic        rreq;

  always #10 clk = ~clk;

  palette_lut dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .wsize_i(wsize), .refresh_clr_i(rclr),
    .pix_i(pix), .rgb_o(rgb), .refresh_req_o(rreq)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] r_m [256];
  logic [7:0] g_m [256];
  logic [7:0] b_m [256];
  logic [7:0] ptr_m;
  int         ph_m;
  logic       req_m;

  function automatic logic [23:0] exp_rgb(input logic [7:0] p);
    return {r_m[p], g_m[p], b_m[p]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_wr(input logic [3:0] a, input logic [31:0] d, input int n);
    if (a == 4'h0) begin
      ptr_m = d[7:0]; ph_m = 0;
    end else if (a == 4'h4) begin
      for (int k = 0; k < n; k++) begin
        logic [7:0] b;
        b = 8'(d >> (8 * (n - 1 - k)));
        case (ph_m)
          0: begin r_m[ptr_m] = b; ph_m = 1; end
          1: begin g_m[ptr_m] = b; ph_m = 2; end
          default: begin b_m[ptr_m] = b; ph_m = 0; ptr_m = ptr_m + 8'd1; end
        endcase
      end
      req_m = 1'b1;
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input int n);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; wsize = 2'(n - 1);
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(a, d, n);
  endtask

  task automatic look(input string tag, input logic [7:0] p);
    @(negedge clk);
    pix = p;
    @(negedge clk);
    chk(tag, 32'(rgb), 32'(exp_rgb(p)));
  endtask

  initial begin
    for (int e = 0; e < 256; e++) begin r_m[e] = 0; g_m[e] = 0; b_m[e] = 0; end
    ptr_m = 0; ph_m = 0; req_m = 1'b1;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset refresh_req", 32'(rreq), 32'd1);
    look("R1 reset entry 0", 8'd0);
    look("R1 reset entry 255", 8'd255);
    look("R1 reset entry 77", 8'd77);

    // R8: clear, pointer write keeps it low, data sets it
    @(negedge clk); rclr = 1'b1; @(negedge clk); rclr = 1'b0; req_m = 1'b0;
    chk("R8 clear", 32'(rreq), 32'(req_m));
    bus_wr(4'h0, 32'h10, 1);
    chk("R8 ptr write no set", 32'(rreq), 32'd0);

    // R1/R3: first bytes after reset land in entry 0x10 per pointer, R,G,B order
    bus_wr(4'h4, 32'hAA, 1);
    chk("R8 data write sets", 32'(rreq), 32'd1);
    bus_wr(4'h4, 32'hBB, 1);
    bus_wr(4'h4, 32'hCC, 1);
    look("R3 rgb order entry 0x10", 8'h10);
    chk("R3 exact value", 32'(rgb), 32'h00AABBCC);
    bus_wr(4'h4, 32'h11, 1);
    look("R4 pointer advanced to 0x11", 8'h11);
    chk("R4 red of 0x11", 32'(rgb), 32'h00110000);

    // R2: pointer write mid-entry resets phase
    bus_wr(4'h0, 32'hFFFF_FF20, 1);
    bus_wr(4'h4, 32'h55, 1);
    look("R2 phase back to red", 8'h20);
    chk("R2 exact", 32'(rgb), 32'h00550000);

    // R4: wrap 255 -> 0 with a four-byte write; R5 byte order
    bus_wr(4'h0, 32'hFF, 1);
    bus_wr(4'h4, 32'h01020304, 4);
    look("R5 word into entry 255", 8'hFF);
    chk("R5 exact 255", 32'(rgb), 32'h00010203);
    look("R4 wrap to entry 0", 8'h00);
    chk("R4 exact 0", 32'(rgb), 32'h00040000);

    // R5: two- and three-byte writes, upper lanes ignored
    bus_wr(4'h0, 32'h30, 1);
    bus_wr(4'h4, 32'hEEEE_1234, 2);
    bus_wr(4'h4, 32'hEE56_789A, 3);
    look("R5 half+triple entry 0x30", 8'h30);
    chk("R5 exact 0x30", 32'(rgb), 32'h00123456);
    look("R5 spill into 0x31", 8'h31);
    chk("R5 exact 0x31", 32'(rgb), 32'h00789A00);

    // R9: unmapped offsets ignored
    @(negedge clk); rclr = 1'b1; @(negedge clk); rclr = 1'b0; req_m = 1'b0;
    bus_wr(4'h8, 32'hDEADBEEF, 4);
    bus_wr(4'h5, 32'h77, 1);
    chk("R9 refresh untouched", 32'(rreq), 32'd0);
    bus_wr(4'h4, 32'h9B, 1);
    look("R9 sequence continued at 0x31 blue", 8'h31);
    chk("R9 exact 0x31", 32'(rgb), 32'h00789A9B);

    // R8: clear and data write in same cycle, write wins
    @(negedge clk);
    rclr = 1'b1; wr_en = 1'b1; addr = 4'h4; wdata = 32'h44; wsize = 2'd0;
    @(negedge clk);
    rclr = 1'b0; wr_en = 1'b0; model_wr(4'h4, 32'h44, 1);
    chk("R8 set beats clear", 32'(rreq), 32'd1);

    // R7: write and read of the same entry in one cycle
    bus_wr(4'h0, 32'h40, 1);
    bus_wr(4'h4, 32'h0A0B0C, 3);
    begin
      logic [23:0] old_v;
      old_v = exp_rgb(8'h40);
      @(negedge clk);
      pix = 8'h40; wr_en = 1'b1; addr = 4'h0; wdata = 32'h40; wsize = 2'd0;
      @(negedge clk);
      wr_en = 1'b0; model_wr(4'h0, 32'h40, 1);
      @(negedge clk);
      wr_en = 1'b1; addr = 4'h4; wdata = 32'h00C1C2C3; wsize = 2'd2;
      @(negedge clk);
      wr_en = 1'b0; model_wr(4'h4, 32'h00C1C2C3, 3);
      chk("R7 old value first", 32'(rgb), 32'(old_v));
      @(negedge clk);
      chk("R7 new value next", 32'(rgb), 32'h00C1C2C3);
    end

    // R3/R4/R5/R6: random stream against the model
    for (int i = 0; i < 400; i++) begin
      int sel;
      int n;
      sel = int'($urandom_range(0, 9));
      n = int'($urandom_range(1, 4));
      if (sel < 2)      bus_wr(4'h0, $urandom(), 1);
      else if (sel < 9) bus_wr(4'h4, $urandom(), n);
      else              bus_wr(4'($urandom_range(8, 15)), $urandom(), n);
      if (i % 40 == 39) begin
        look("R6 random ptr entry", ptr_m);
        look("R6 random prev entry", ptr_m - 8'd1);
        chk("R8 random refresh", 32'(rreq), 32'(req_m));
      end
    end
    for (int i = 0; i < 32; i++) look("R6 random sweep", 8'($urandom()));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule